// File: doc/BRIEF.md
# Differential Clock Output Stop Controller

This block places a free-running source clock onto a true/complement output pair and parks the pair in a defined state when the system requests power-down. Each output has its own drive-enable, so the pad can be released to high impedance. The stop state depends on a mode strap and a float-select bit. In the hold mode, a stop either holds the true output high and the complement low, or floats both outputs. In the low mode, both outputs are driven low and the float-select bit has no effect.

The active-low power-down request passes through a synchronizer clocked by the source clock. Stopping and restarting therefore happen only at rising edges of that clock. When the pair restarts, its first high phase is a full one. Each output also has its own enable bit. Clearing an enable forces that output low at once, with no wait for a clock edge. The mode strap and the float-select bit act combinationally on the stop state.

Top module: `dclk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, the power-down synchronizer is cleared and the pair is in its stop state. After release, the pair starts running only once `pd_n` has been sampled high at SYNC_STAGES (default 2) rising edges of `clk_src`.
- R2: While running, `out_t` equals `clk_src`, `out_c` is its exact inverse, and `oe_t` and `oe_c` are both 1.
- R3: When stopped with `mode_low`=0 and `float_sel`=0, `out_t`=1 and `out_c`=0, and both are driven (`oe`=1).
- R4: When stopped with `mode_low`=0 and `float_sel`=1, `oe_t`=0 and `oe_c`=0 (high impedance), and both levels read 0.
- R5: When stopped with `mode_low`=1, both outputs are driven low, whatever the value of `float_sel`.
- R6: When `en_t` or `en_c` is 0, that output reads 0 with its `oe` at 1, at once and regardless of clock or stop state. The other output is unaffected.
- R7: A change of `pd_n` that is present at rising edge k takes effect at rising edge k+SYNC_STAGES-1. Before that edge, the pair keeps its previous state.
- R8: On restart, `out_t` stays at its stop level until the rising edge at which the pair resumes. From that edge it is high for a full half period, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock; also clocks the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request, asynchronous to the block |
| mode_low | input | 1 | Mode strap: 0 = hold/float stop, 1 = both-low stop |
| float_sel | input | 1 | In hold mode, 1 floats the pair when stopped |
| en_t | input | 1 | Enable of the true output; 0 forces it low |
| en_c | input | 1 | Enable of the complement output; 0 forces it low |
| out_t | output | 1 | True output level |
| oe_t | output | 1 | Drive enable of the true output (0 = high impedance) |
| out_c | output | 1 | Complement output level |
| oe_c | output | 1 | Drive enable of the complement output (0 = high impedance) |

## Verification
Enable, mode and float-select changes act with no delay, so the bench checks them half a nanosecond after the input change, well before the next clock edge. A `pd_n` change lands at the second rising edge after it is first sampled. The bench checks the unchanged state just after the first edge and again just before the second, then checks the new state just after the second. For the vector table, each entry waits three rising edges, which covers the synchronizer. It then samples once in the low phase and once in the high phase of `clk_src`, so a running pair is told apart from a parked one.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    // Stop behaviour of one output pin
    typedef struct packed {
        logic level;   // level while parked
        logic drive;   // 1 = driven, 0 = high impedance
    } pin_stop_t;

    typedef enum logic {
        MODE_HOLD = 1'b0,   // true high / complement low, or float
        MODE_LOW  = 1'b1    // both driven low
    } stop_mode_e;

endpackage

// File: rtl/dclk_pd_sync.sv
module dclk_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic pd_n,
    output logic run
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = STAGES'({st_q.chain, pd_n});
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.chain[STAGES-1];

    // R7
    run_rise_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $rose(run) |-> $past(pd_n));

    // R7
    run_fall_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $fell(run) |-> !$past(pd_n));

endmodule

// File: rtl/dclk_stop_decode.sv
module dclk_stop_decode
    import dclk_pkg::*;
(
    input  stop_mode_e mode,
    input  logic       float_sel,
    output pin_stop_t  stop_t,
    output pin_stop_t  stop_c
);
    always_comb begin
        stop_t = '{level: 1'b0, drive: 1'b1};
        stop_c = '{level: 1'b0, drive: 1'b1};
        unique case (mode)
            MODE_HOLD: begin
                if (float_sel) begin
                    stop_t = '{level: 1'b0, drive: 1'b0};
                    stop_c = '{level: 1'b0, drive: 1'b0};
                end else begin
                    stop_t = '{level: 1'b1, drive: 1'b1};
                    stop_c = '{level: 1'b0, drive: 1'b1};
                end
            end
            MODE_LOW: begin
                stop_t = '{level: 1'b0, drive: 1'b1};
                stop_c = '{level: 1'b0, drive: 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dclk_out_gate.sv
module dclk_out_gate
    import dclk_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic      clk_src,
    input  logic      run,
    input  logic      en,
    input  pin_stop_t stop,
    output logic      lvl,
    output logic      oe
);
    always_comb begin
        if (!en) begin
            lvl = 1'b0;
            oe  = 1'b1;
        end else if (run) begin
            lvl = clk_src ^ INVERT;
            oe  = 1'b1;
        end else begin
            lvl = stop.level;
            oe  = stop.drive;
        end
    end
endmodule

// File: rtl/dclk_stop_ctrl.sv
module dclk_stop_ctrl
    import dclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int NUM_OUT    = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic pd_n,
    input  logic mode_low,
    input  logic float_sel,
    input  logic en_t,
    input  logic en_c,
    output logic out_t,
    output logic oe_t,
    output logic out_c,
    output logic oe_c
);
    logic                run;
    pin_stop_t           stop_v [NUM_OUT];
    logic [NUM_OUT-1:0]  en_v;
    logic [NUM_OUT-1:0]  lvl_v;
    logic [NUM_OUT-1:0]  oe_v;
    stop_mode_e          mode;

    assign mode = stop_mode_e'(mode_low);
    assign en_v = {en_c, en_t};

    dclk_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .run     (run)
    );

    dclk_stop_decode u_dec (
        .mode      (mode),
        .float_sel (float_sel),
        .stop_t    (stop_v[0]),
        .stop_c    (stop_v[1])
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        dclk_out_gate #(.INVERT(i[0])) u_gate (
            .clk_src (clk_src),
            .run     (run),
            .en      (en_v[i]),
            .stop    (stop_v[i]),
            .lvl     (lvl_v[i]),
            .oe      (oe_v[i])
        );
    end

    assign out_t = lvl_v[0];
    assign out_c = lvl_v[1];
    assign oe_t  = oe_v[0];
    assign oe_c  = oe_v[1];

    // R6
    always_comb begin
        en_t_low_chk: assert (en_t || (!out_t && oe_t));
        en_c_low_chk: assert (en_c || (!out_c && oe_c));
    end

    // R2
    pair_inverse_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (run && en_t && en_c) |-> (out_c == !out_t) && oe_t && oe_c);

    // R3
    hold_stop_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!run && !mode_low && !float_sel && en_t && en_c)
            |-> out_t && !out_c && oe_t && oe_c);

    // R4
    float_stop_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!run && !mode_low && float_sel && en_t && en_c) |-> !oe_t && !oe_c);

    // R5
    low_stop_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!run && mode_low && en_t && en_c)
            |-> !out_t && !out_c && oe_t && oe_c);

endmodule

// File: tb/sim_dclk_stop_ctrl.sv
`timescale 1ns/100ps
module sim_dclk_stop_ctrl;
    logic clk_src = 1'b0;
    logic rst_n, pd_n, mode_low, float_sel, en_t, en_c;
    logic out_t, oe_t, out_c, oe_c;
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 0;

    always #2.5 clk_src = ~clk_src;

    dclk_stop_ctrl u0 (
        .clk_src (clk_src), .rst_n (rst_n), .pd_n (pd_n),
        .mode_low (mode_low), .float_sel (float_sel),
        .en_t (en_t), .en_c (en_c),
        .out_t (out_t), .oe_t (oe_t), .out_c (out_c), .oe_c (oe_c)
    );

    // {mode_low, float_sel, en_t, en_c, pd_n, out_t, oe_t, out_c, oe_c}
    // expected outputs are for the low phase of clk_src
    localparam logic [8:0] VEC [8] = '{
        9'b0_0_1_1_1_0_1_1_1,   // R2 running, hold mode
        9'b0_0_1_1_0_1_1_0_1,   // R3 hold stop
        9'b0_1_1_1_0_0_0_0_0,   // R4 float stop
        9'b1_0_1_1_0_0_1_0_1,   // R5 low stop
        9'b1_1_1_1_0_0_1_0_1,   // R5 select ignored
        9'b0_0_0_1_0_0_1_0_1,   // R6 true disabled over hold stop
        9'b0_1_1_0_0_0_0_0_1,   // R6 complement disabled over float
        9'b1_1_1_1_1_0_1_1_1    // R2 running, low mode
    };

    function automatic string vec_req(int i);
        case (i)
            0, 7:    return "R2";
            1:       return "R3";
            2:       return "R4";
            3, 4:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, string what, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got t/oe_t/c/oe_c=%b expected %b at %0t",
                     req, what, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs();
        return {out_t, oe_t, out_c, oe_c};
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pd_n = 1; mode_low = 0; float_sel = 0; en_t = 1; en_c = 1;
        #1;
        // R1 reset: parked in hold stop state
        check("R1", "in reset", outs(), 4'b1101);
        repeat (2) @(negedge clk_src);
        rst_n = 1;
        @(posedge clk_src); @(negedge clk_src); #0.5;
        check("R1", "one edge after release", outs(), 4'b1101);
        @(posedge clk_src); @(negedge clk_src); #0.5;
        check("R1", "running after two edges", outs(), 4'b0111);

        for (int i = 0; i < 8; i++) begin
            logic [3:0] exp_lo, exp_hi;
            @(negedge clk_src);
            {mode_low, float_sel, en_t, en_c, pd_n} = VEC[i][8:4];
            exp_lo = VEC[i][3:0];
            exp_hi = exp_lo;
            if (pd_n && en_t) exp_hi[3] = ~exp_lo[3];
            if (pd_n && en_c) exp_hi[1] = ~exp_lo[1];
            repeat (3) @(posedge clk_src);
            @(negedge clk_src); #0.5;
            check(vec_req(i), "low phase", outs(), exp_lo);
            @(posedge clk_src); #0.5;
            check(vec_req(i), "high phase", outs(), exp_hi);
        end

        // R6: disable while running takes effect before any edge
        @(negedge clk_src);
        mode_low = 0; float_sel = 0; en_t = 1; en_c = 1; pd_n = 1;
        repeat (3) @(posedge clk_src);
        @(posedge clk_src); #0.5;
        en_t = 0; #0.5;
        check("R6", "true forced low mid high phase", outs(), 4'b0101);
        en_t = 1; en_c = 0; #0.5;
        check("R6", "comp forced low, true unaffected", outs(), 4'b1101);
        en_c = 1;

        // R7: entry latency in low mode
        @(negedge clk_src);
        mode_low = 1; pd_n = 0;
        @(posedge clk_src); #0.5;
        check("R7", "still running after first edge", outs(), 4'b1101);
        @(posedge clk_src); #0.5;
        check("R7", "stopped after second edge", outs(), 4'b0101);

        // R8: restart produces a full high phase starting at an edge
        @(negedge clk_src);
        pd_n = 1;
        @(posedge clk_src); @(negedge clk_src); #0.5;
        check("R7", "still parked after first edge", outs(), 4'b0101);
        #1.5;
        check("R8", "parked just before resume edge", outs(), 4'b0101);
        @(posedge clk_src); #0.5;
        check("R8", "high right after resume edge", outs(), 4'b1101);
        #1.5;
        check("R8", "high held through phase", outs(), 4'b1101);

        // R1: reset reasserted parks the pair again
        @(negedge clk_src);
        mode_low = 0;
        rst_n = 0; #0.5;
        check("R1", "reset reasserted", outs(), 4'b1101);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule